// File: doc/BRIEF.md
# Scoreboarded Multi-Warp Issue Scheduler

This block picks, on every clock, which of up to 64 resident warps may issue their next instruction. A warp is a group of 32 threads that issue together, and the scheduler treats it as one unit. Each warp slot presents one decoded instruction: a unit class, a destination register and two source registers. Selection is combinational from the presented instructions and the registered scheduler state. The granted warps appear on up to four issue slots, and a per-warp advance strobe tells the front end to step that warp to its next instruction.

Long memory latency is hidden, not waited out. A load issues at once and marks its destination register as pending in that warp's scoreboard. Only a later instruction that touches a pending register is held back, and only its own warp waits. Meanwhile other ready warps keep issuing. A writeback port clears the pending mark when the load data returns. Arithmetic units are plentiful and special-function units are scarce, so a warp whose instruction needs a unit class that is used up this cycle is skipped. A rotating priority makes sure no ready warp starves. Warps are not bound into fixed sets of four: any mix of ready warps may be chosen.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every scoreboard bit is clear and the priority search begins at warp 0; with no valid instruction, no slot is valid and no advance strobe is raised.
- R2: At most ISSUE_WIDTH (4) distinct warps are granted per cycle. Granted warps fill slots from slot 0 upward in priority order, each slot carrying the warp id. Exactly the granted warps have their bit set in warp_advance.
- R3: The priority search starts at the warp after the last warp granted in the most recent cycle that granted anything, and wraps from warp NUM_WARPS-1 to warp 0. A cycle with no grant leaves the start point unchanged.
- R4: Class codes are 0 = arithmetic, 1 = special-function, 2 = load, and 3 = reserved, which never issues. At most ALU_UNITS (4) arithmetic, SFU_UNITS (1) special-function and LSU_UNITS (2) load instructions are granted per cycle. A warp needing an exhausted class is skipped, and the search goes on to later warps.
- R5: A granted load does not stall its warp. From the next cycle the load's destination register is pending for that warp only.
- R6: An instruction whose first source, second source or destination register is pending in its own warp's scoreboard is not granted. The same register number in another warp does not block that warp.
- R7: A writeback (wb_warp, wb_reg) clears that one pending bit starting with the next cycle, so there is no same-cycle bypass. A writeback naming another warp leaves a blocked warp blocked.
- R8: The grant outputs follow the presented instructions in the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | NUM_WARPS | Warp w presents an instruction |
| instr_class | input | 2*NUM_WARPS | Unit class per warp, 2 bits each |
| instr_dst | input | REG_IDW*NUM_WARPS | Destination register per warp |
| instr_src0 | input | REG_IDW*NUM_WARPS | First source register per warp |
| instr_src1 | input | REG_IDW*NUM_WARPS | Second source register per warp |
| wb_valid | input | 1 | Load result returning this cycle |
| wb_warp | input | WARP_IDW | Warp of the returning load |
| wb_reg | input | REG_IDW | Register of the returning load |
| issue_valid | output | ISSUE_WIDTH | Slot k carries a grant |
| issue_warp | output | WARP_IDW*ISSUE_WIDTH | Warp id per slot |
| warp_advance | output | NUM_WARPS | Warp w issued this cycle |

## Verification
A table walk presents eight warps at a time as all-arithmetic, all-special-function, mixed and sparse masks. Comparing the grant masks from one row to the next separates a correct rotating start point from a fixed one, shows the wrap past the top warp, and shows the special-function limit skipping one warp while later arithmetic warps still issue. Directed sequences then issue three loads against the two load units. They follow dependent and independent instructions across warps that share register numbers, send writebacks to the wrong warp and to the right one, and check the cycle in which a held instruction is released. A reserved class code is presented next to a valid warp at the top of the range.

// File: rtl/warp_sched_pkg.sv
// Shared types for the warp issue scheduler.
package warp_sched_pkg;
    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_SFU   = 2'd1,
        CLS_LOAD  = 2'd2,
        CLS_RSVD  = 2'd3
    } unit_class_e;
endpackage

// File: rtl/warp_scoreboard.sv
// Per-warp register scoreboard.
// Holds one pending-write bit for each (warp, register) pair. A granted load
// sets its destination bit, and a writeback clears one bit. Each warp gets a
// hazard flag when any register its instruction names is pending.
// Assumes one writeback per cycle. A set and a clear of the same bit in one
// cycle leave it set.
module warp_scoreboard #(
    parameter int NUM_WARPS = 64,
    parameter int NUM_REGS  = 32,
    localparam int WARP_IDW = $clog2(NUM_WARPS),
    localparam int REG_IDW  = $clog2(NUM_REGS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_WARPS-1:0]                set_en,
    input  logic [NUM_WARPS-1:0][REG_IDW-1:0]   dst,
    input  logic [NUM_WARPS-1:0][REG_IDW-1:0]   src0,
    input  logic [NUM_WARPS-1:0][REG_IDW-1:0]   src1,
    input  logic                                wb_valid,
    input  logic [WARP_IDW-1:0]                 wb_warp,
    input  logic [REG_IDW-1:0]                  wb_reg,
    output logic [NUM_WARPS-1:0]                hazard
);
    logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_q;
    logic                               wb_overlap;

    // Update pending bits: clear on writeback, then set on load grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int w = 0; w < NUM_WARPS; w++) begin
                if (wb_valid && wb_warp == WARP_IDW'(w))
                    pend_q[w][wb_reg] <= 1'b0;
                if (set_en[w])
                    pend_q[w][dst[w]] <= 1'b1;
            end
        end
    end

    // Flag warps whose presented instruction names a pending register.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_hazard
        assign hazard[w] = pend_q[w][src0[w]] | pend_q[w][src1[w]] | pend_q[w][dst[w]];

        // A granted load marks its destination pending (R5).
        assert_load_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_en[w] |=> pend_q[w][$past(dst[w])]);
    end

    // Detect a writeback that collides with a load set in the same cycle.
    always_comb wb_overlap = set_en[wb_warp] && (dst[wb_warp] == wb_reg);

    // A writeback without a colliding set leaves the bit clear (R7).
    assert_wb_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_overlap) |=> !pend_q[$past(wb_warp)][$past(wb_reg)]);
endmodule

// File: rtl/issue_picker.sv
// Rotating multi-grant picker with per-class unit limits.
// Walks all warps once, starting after the last warp it granted. It grants
// eligible warps while slots and units of the needed class remain. Class 3 is
// never granted. Grants are placed in slots in search order.
// Assumes eligibility already folds in instruction valid and hazards.
module issue_picker import warp_sched_pkg::*; #(
    parameter int NUM_WARPS   = 64,
    parameter int ISSUE_WIDTH = 4,
    parameter int ALU_UNITS   = 4,
    parameter int SFU_UNITS   = 1,
    parameter int LSU_UNITS   = 2,
    localparam int WARP_IDW   = $clog2(NUM_WARPS),
    localparam int SLOT_IDW   = (ISSUE_WIDTH > 1) ? $clog2(ISSUE_WIDTH) : 1
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic        [NUM_WARPS-1:0]             eligible,
    input  unit_class_e [NUM_WARPS-1:0]             cls,
    output logic        [NUM_WARPS-1:0]             grant,
    output logic        [ISSUE_WIDTH-1:0]           slot_vld,
    output logic        [ISSUE_WIDTH-1:0][WARP_IDW-1:0] slot_id
);
    logic [WARP_IDW-1:0] ptr_q;
    logic [WARP_IDW-1:0] last_pick;

    // Walk warps in rotated order and hand out slots and units.
    always_comb begin
        int n, alu_n, sfu_n, ld_n;
        logic [WARP_IDW-1:0] wi;
        logic ok;
        grant     = '0;
        slot_vld  = '0;
        slot_id   = '0;
        last_pick = ptr_q;
        n = 0; alu_n = 0; sfu_n = 0; ld_n = 0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            wi = WARP_IDW'((int'(ptr_q) + 1 + i) % NUM_WARPS);
            ok = 1'b0;
            if (eligible[wi] && n < ISSUE_WIDTH) begin
                case (cls[wi])
                    CLS_ARITH: ok = (alu_n < ALU_UNITS);
                    CLS_SFU:   ok = (sfu_n < SFU_UNITS);
                    CLS_LOAD:  ok = (ld_n  < LSU_UNITS);
                    default:   ok = 1'b0;
                endcase
            end
            if (ok) begin
                grant[wi]              = 1'b1;
                slot_vld[SLOT_IDW'(n)] = 1'b1;
                slot_id[SLOT_IDW'(n)]  = wi;
                last_pick              = wi;
                case (cls[wi])
                    CLS_ARITH: alu_n++;
                    CLS_SFU:   sfu_n++;
                    default:   ld_n++;
                endcase
                n++;
            end
        end
    end

    // Remember the last granted warp as the next search origin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= WARP_IDW'(NUM_WARPS - 1);
        else if (|grant)
            ptr_q <= last_pick;
    end

    assert_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= ISSUE_WIDTH);
    assert_only_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~eligible) == '0);
    assert_idle_keeps_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/warp_issue_sched.sv
// Top of the scoreboarded warp issue scheduler.
// Unpacks the per-warp instruction fields, masks warps blocked by the
// scoreboard, and runs the picker. Loads it grants are fed back to the
// scoreboard. Issue is combinational from the presented instructions.
// Assumes non-load instructions have a short fixed latency and need no
// scoreboard tracking.
module warp_issue_sched import warp_sched_pkg::*; #(
    parameter int NUM_WARPS   = 64,
    parameter int NUM_REGS    = 32,
    parameter int ISSUE_WIDTH = 4,
    parameter int ALU_UNITS   = 4,
    parameter int SFU_UNITS   = 1,
    parameter int LSU_UNITS   = 2,
    localparam int WARP_IDW   = $clog2(NUM_WARPS),
    localparam int REG_IDW    = $clog2(NUM_REGS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_WARPS-1:0]            instr_valid,
    input  logic [2*NUM_WARPS-1:0]          instr_class,
    input  logic [REG_IDW*NUM_WARPS-1:0]    instr_dst,
    input  logic [REG_IDW*NUM_WARPS-1:0]    instr_src0,
    input  logic [REG_IDW*NUM_WARPS-1:0]    instr_src1,
    input  logic                            wb_valid,
    input  logic [WARP_IDW-1:0]             wb_warp,
    input  logic [REG_IDW-1:0]              wb_reg,
    output logic [ISSUE_WIDTH-1:0]          issue_valid,
    output logic [WARP_IDW*ISSUE_WIDTH-1:0] issue_warp,
    output logic [NUM_WARPS-1:0]            warp_advance
);
    unit_class_e [NUM_WARPS-1:0]              cls_w;
    logic        [NUM_WARPS-1:0][REG_IDW-1:0] dst_w, src0_w, src1_w;
    logic        [NUM_WARPS-1:0]              hazard, eligible, grant, load_set;
    logic        [ISSUE_WIDTH-1:0][WARP_IDW-1:0] slot_id;
    int                                       sfu_grants;

    // Unpack per-warp fields and form the load-set strobes.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_unpack
        assign cls_w[w]    = unit_class_e'(instr_class[2*w +: 2]);
        assign dst_w[w]    = instr_dst [REG_IDW*w +: REG_IDW];
        assign src0_w[w]   = instr_src0[REG_IDW*w +: REG_IDW];
        assign src1_w[w]   = instr_src1[REG_IDW*w +: REG_IDW];
        assign load_set[w] = grant[w] && (cls_w[w] == CLS_LOAD);
    end

    // A warp may compete only with a valid, hazard-free instruction.
    assign eligible = instr_valid & ~hazard;

    warp_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb (
        .clk(clk), .rst_n(rst_n), .set_en(load_set),
        .dst(dst_w), .src0(src0_w), .src1(src1_w),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .hazard(hazard)
    );

    issue_picker #(.NUM_WARPS(NUM_WARPS), .ISSUE_WIDTH(ISSUE_WIDTH),
                   .ALU_UNITS(ALU_UNITS), .SFU_UNITS(SFU_UNITS),
                   .LSU_UNITS(LSU_UNITS)) u_pick (
        .clk(clk), .rst_n(rst_n), .eligible(eligible), .cls(cls_w),
        .grant(grant), .slot_vld(issue_valid), .slot_id(slot_id)
    );

    assign issue_warp   = slot_id;
    assign warp_advance = grant;

    // Count granted special-function instructions for the limit check.
    always_comb begin
        sfu_grants = 0;
        for (int w = 0; w < NUM_WARPS; w++)
            if (warp_advance[w] && instr_class[2*w +: 2] == 2'd1) sfu_grants++;
    end

    assert_slots_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_valid) == $countones(warp_advance));
    assert_sfu_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sfu_grants <= SFU_UNITS);
    assert_valid_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_advance & ~instr_valid) == '0);
endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  instr_valid;
    logic [127:0] instr_class;
    logic [319:0] instr_dst, instr_src0, instr_src1;
    logic         wb_valid;
    logic [5:0]   wb_warp;
    logic [4:0]   wb_reg;
    logic [3:0]   issue_valid;
    logic [23:0]  issue_warp;
    logic [63:0]  warp_advance;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    warp_issue_sched uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_class(instr_class), .instr_dst(instr_dst),
        .instr_src0(instr_src0), .instr_src1(instr_src1),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .warp_advance(warp_advance)
    );

    // Rows: {valid[7:0], sfu_mask[7:0], expected grant[7:0], first slot id}
    localparam logic [29:0] VEC [8] = '{
        {8'hFF, 8'h00, 8'h0F, 6'd0},
        {8'hFF, 8'h00, 8'hF0, 6'd4},
        {8'hFF, 8'h00, 8'h0F, 6'd0},
        {8'hFF, 8'hFF, 8'h10, 6'd4},
        {8'h0F, 8'h03, 8'h0D, 6'd0},
        {8'h00, 8'h00, 8'h00, 6'd0},
        {8'h22, 8'h00, 8'h22, 6'd5},
        {8'hFF, 8'h00, 8'h3C, 6'd2}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        instr_valid = '0; instr_class = '0; instr_dst = '0;
        instr_src0 = '0; instr_src1 = '0;
        wb_valid = 1'b0; wb_warp = '0; wb_reg = '0;
    endtask

    task automatic put(input int w, input logic [1:0] c, input logic [4:0] d,
                       input logic [4:0] s0, input logic [4:0] s1);
        instr_valid[w]       = 1'b1;
        instr_class[2*w +: 2] = c;
        instr_dst[5*w +: 5]   = d;
        instr_src0[5*w +: 5]  = s0;
        instr_src1[5*w +: 5]  = s1;
    endtask

    task automatic do_reset();
        @(negedge clk); clear_all(); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle after reset
        #1;
        check("R1 idle slots", 64'(issue_valid), 64'h0);
        check("R1 idle advance", warp_advance, 64'h0);

        // Table walk: rotation (R3), slot fill (R2), class limits (R4), same-cycle (R8)
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            clear_all();
            for (int w = 0; w < 8; w++)
                if (VEC[r][29-w-0 -: 1] == 1'b1 || VEC[r][22+w] == 1'b1) begin end
            for (int w = 0; w < 8; w++)
                if (VEC[r][22+w])
                    put(w, VEC[r][14+w] ? 2'd1 : 2'd0, 5'd0, 5'd0, 5'd0);
            #1;
            check($sformatf("R3 R4 row %0d grant mask", r), warp_advance, 64'(VEC[r][13:6]));
            check($sformatf("R2 row %0d slot count", r), 64'($countones(issue_valid)),
                  64'($countones(VEC[r][13:6])));
            if (VEC[r][13:6] != 8'h0)
                check($sformatf("R2 R8 row %0d slot0 id", r), 64'(issue_warp[5:0]), 64'(VEC[r][5:0]));
        end

        do_reset();
        // R4: three loads, two load units
        @(negedge clk); clear_all();
        put(0, 2'd2, 5'd1, 5'd0, 5'd0);
        put(1, 2'd2, 5'd2, 5'd0, 5'd0);
        put(2, 2'd2, 5'd3, 5'd0, 5'd0);
        #1;
        check("R4 load unit limit", warp_advance, 64'h3);

        // R5 R6: dependent warp 0 waits, others (incl. same reg number) go
        @(negedge clk); clear_all();
        put(0, 2'd0, 5'd4, 5'd1, 5'd0);
        put(1, 2'd0, 5'd4, 5'd9, 5'd0);
        put(2, 2'd2, 5'd3, 5'd0, 5'd0);
        put(3, 2'd0, 5'd6, 5'd0, 5'd1);
        #1;
        check("R5 R6 load no stall, dependent held", warp_advance, 64'hE);
        check("R2 slot0 after rotation", 64'(issue_warp[5:0]), 64'd2);

        // R6 dest pending; R7 writeback to other warp does not release warp 0
        @(negedge clk); clear_all();
        put(0, 2'd0, 5'd4, 5'd1, 5'd0);
        put(2, 2'd0, 5'd3, 5'd0, 5'd0);
        wb_valid = 1'b1; wb_warp = 6'd1; wb_reg = 5'd1;
        #1;
        check("R6 R7 dest pending and wrong-warp writeback", warp_advance, 64'h0);

        // R7: matching writeback, no same-cycle release
        @(negedge clk); clear_all();
        put(0, 2'd0, 5'd4, 5'd1, 5'd0);
        put(2, 2'd0, 5'd3, 5'd0, 5'd0);
        wb_valid = 1'b1; wb_warp = 6'd0; wb_reg = 5'd1;
        #1;
        check("R7 no bypass in writeback cycle", warp_advance, 64'h0);

        // R7: released the next cycle; warp 2 stays blocked
        @(negedge clk); clear_all();
        put(0, 2'd0, 5'd4, 5'd1, 5'd0);
        put(2, 2'd0, 5'd3, 5'd0, 5'd0);
        #1;
        check("R7 released after writeback", warp_advance, 64'h1);

        // R4 reserved class never issues; R3 wrap reaches top warp
        @(negedge clk); clear_all();
        put(5, 2'd3, 5'd0, 5'd0, 5'd0);
        put(63, 2'd0, 5'd0, 5'd0, 5'd0);
        #1;
        check("R4 reserved class skipped", warp_advance, 64'h8000_0000_0000_0000);
        check("R3 top warp id in slot0", 64'(issue_warp[5:0]), 64'd63);

        @(negedge clk); clear_all();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule